// File: doc/BRIEF.md
# Endian-Configurable Byte-Lane Load/Store Unit

This block sits between a 32-bit register datapath and a byte-addressed memory port that is one word wide. For a store it builds the word to write and the byte-write strobes. For a load it picks the addressed byte, halfword or word out of the memory word and zero-extends it to 32 bits. Byte addresses count single bytes, so the word that starts at byte address 4 holds bytes 4 to 7.

A byte-order mode is sampled from `cfg_big_endian` on every clock edge while `rst_n` is low, and is then held until the next reset. In little-endian mode the byte at the lowest address sits in the least significant lane. In big-endian mode it sits in the most significant lane. So the same address and data give different byte results in the two modes. Halfword and word accesses must be naturally aligned. A misaligned access reports an error and touches no memory.

Requests arrive on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the memory strobes (`mem_we`, `mem_re`) are driven only in that cycle. The memory is expected to return `mem_rdata` in the same cycle as `mem_re`. Each accepted request gives one response on the registered `rsp_*` channel in the next cycle. While the consumer holds `rsp_ready` low, the response stays frozen and `req_ready` stays low, so back-pressure reaches the requester without any request being lost.

Top module: `endian_lane_lsu`

## Requirements
- R1: The byte-order mode equals the level of `cfg_big_endian` at the last clock edge with `rst_n` low (1 = big-endian). Changes of that pin after reset have no effect on any access.
- R2: A byte load returns the byte in lane `addr[1:0]` (little-endian) or lane `3 - addr[1:0]` (big-endian), where lane k is bits `8k+7:8k`, zero-extended. With memory word 0x11223344 at address 0, address 0 gives 0x00000044 in little-endian mode and 0x00000011 in big-endian mode.
- R3: A halfword load returns bits 15:0 when `addr[1]` XOR mode is 0 and bits 31:16 when it is 1, zero-extended.
- R4: A word load returns `mem_rdata` unchanged in both modes.
- R5: A byte store (`req_size` = 2'b00) copies `req_wdata[7:0]` into all four lanes and raises exactly the one strobe bit of the lane chosen as in R2.
- R6: A halfword store (`req_size` = 2'b01) copies `req_wdata[15:0]` into both halves and raises strobe 4'b0011 or 4'b1100, the half chosen as in R3.
- R7: A word store (`req_size` = 2'b10) writes `req_wdata` unchanged with strobe 4'b1111.
- R8: A halfword access with `addr[0]` = 1, a word access with `addr[1:0]` != 0, or size code 2'b11 gives a response with `rsp_err` = 1 and `rsp_data` = 0, and raises neither `mem_we` nor `mem_re`.
- R9: A request is accepted when `req_valid` and `req_ready` are both high. Its response appears with `rsp_valid` high one cycle later. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response does not change.
- R10: `mem_addr` is `req_addr` with bits 1:0 cleared. `mem_we` (stores) and `mem_re` (loads) are high only in an accepting cycle of an aligned access. Store responses carry `rsp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_big_endian | input | 1 | Byte-order choice sampled during reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_be | output | 4 | Byte-write enables, bit k for lane k |
| mem_wdata | output | 32 | Lane-placed write word |
| mem_rdata | input | 32 | Read word, same cycle as mem_re |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_data | output | 32 | Zero-extended load result |
| rsp_err | output | 1 | Alignment or size error |

## Verification
The checker checks on every cycle that the store strobes have the right shape for each size, that the store data is copied across the lanes, that misaligned or invalid accesses never strobe memory, that memory is strobed only in an accepting cycle at a word-aligned address, that a stalled response stays fixed, and that the mode holds after reset. Which lane is picked in each byte-order mode, the exact load results with zero extension, the mode ignoring the pin after reset, and the timing of a stall and its release are shown only by the bench's vector table and its directed scenarios.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/lsu_lane_decode.sv
// Maps the low address bits and the byte-order mode to lane indices,
// byte strobes and an alignment flag.
module lsu_lane_decode
  import lsu_pkg::*;
#(
  parameter int unsigned NLANES = 4,
  localparam int unsigned LW = $clog2(NLANES)
) (
  input  logic              big,
  input  acc_size_e         size,
  input  logic [LW-1:0]     lo_addr,
  output logic [LW-1:0]     byte_idx,
  output logic [LW-2:0]     half_idx,
  output logic [NLANES-1:0] strobe,
  output logic              misaligned
);
  // Big-endian mirrors the lane order inside the word.
  assign byte_idx = lo_addr ^ {LW{big}};
  assign half_idx = lo_addr[LW-1:1] ^ {(LW-1){big}};

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: strobe[i] = (byte_idx == LW'(i));
        SZ_HALF: strobe[i] = (half_idx == (LW-1)'(i / 2));
        SZ_WORD: strobe[i] = 1'b1;
        default: strobe[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = lo_addr[0];
      SZ_WORD: misaligned = |lo_addr;
      default: misaligned = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_store_align.sv
// Copies the store operand across every lane position it may occupy.
module lsu_store_align
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NLANES = DATA_W / LANE_W
) (
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lane_data
);
  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: lane_data[i*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
        SZ_HALF: lane_data[i*LANE_W +: LANE_W] = wdata[(i%2)*LANE_W +: LANE_W];
        default: lane_data[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
// Picks the addressed byte or halfword from the read word and zero-extends.
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NLANES = DATA_W / LANE_W,
  localparam int unsigned LW = $clog2(NLANES)
) (
  input  acc_size_e         size,
  input  logic [LW-1:0]     byte_idx,
  input  logic [LW-2:0]     half_idx,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  logic [LANE_W-1:0]   sel_byte;
  logic [2*LANE_W-1:0] sel_half;

  assign sel_byte = rdata[byte_idx*LANE_W +: LANE_W];
  assign sel_half = rdata[half_idx*(2*LANE_W) +: 2*LANE_W];

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(DATA_W-LANE_W){1'b0}}, sel_byte};
      SZ_HALF: result = {{(DATA_W-2*LANE_W){1'b0}}, sel_half};
      SZ_WORD: result = rdata;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/lsu_rsp_stage.sv
// One-entry registered response slot with valid/ready on both sides.
module lsu_rsp_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_err   <= in_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/endian_lane_lsu.sv
module endian_lane_lsu
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NLANES = DATA_W / LANE_W,
  localparam int unsigned LW = $clog2(NLANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_endian,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [NLANES-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  logic              big_q;
  acc_size_e         size;
  logic [LW-1:0]     byte_idx;
  logic [LW-2:0]     half_idx;
  logic [NLANES-1:0] strobe;
  logic              misaligned;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] rsp_next;
  logic              take;

  // Byte order follows the pin while reset is held, then stays put.
  always_ff @(posedge clk) begin
    if (!rst_n) big_q <= cfg_big_endian;
  end

  assign size = acc_size_e'(req_size);
  assign take = req_valid && req_ready;

  lsu_lane_decode #(.NLANES(NLANES)) u_dec (
    .big        (big_q),
    .size       (size),
    .lo_addr    (req_addr[LW-1:0]),
    .byte_idx   (byte_idx),
    .half_idx   (half_idx),
    .strobe     (strobe),
    .misaligned (misaligned)
  );

  lsu_store_align #(.DATA_W(DATA_W)) u_st (
    .size      (size),
    .wdata     (req_wdata),
    .lane_data (mem_wdata)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size     (size),
    .byte_idx (byte_idx),
    .half_idx (half_idx),
    .rdata    (mem_rdata),
    .result   (load_val)
  );

  assign mem_addr = {req_addr[ADDR_W-1:LW], {LW{1'b0}}};
  assign mem_be   = strobe;
  assign mem_we   = take && req_write && !misaligned;
  assign mem_re   = take && !req_write && !misaligned;
  assign rsp_next = (req_write || misaligned) ? '0 : load_val;

  lsu_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (rsp_next),
    .in_err    (misaligned),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (rsp_data),
    .out_err   (rsp_err)
  );
endmodule

// File: rtl/endian_lane_lsu_chk.sv
module endian_lane_lsu_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NLANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              big_q,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [NLANES-1:0] mem_be,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_err
);
  logic bad_align;
  assign bad_align = (req_size == 2'b11) ||
                     (req_size == 2'b01 && req_addr[0]) ||
                     (req_size == 2'b10 && req_addr[1:0] != 2'b00);

  // R1: mode fixed once reset is released
  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(big_q));

  // R5: one strobe and replicated byte
  a_r5_byte_store: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b00) |->
      ($countones(mem_be) == 1 && mem_wdata == {NLANES{mem_wdata[7:0]}}));

  // R6: an aligned pair of strobes and replicated half
  a_r6_half_store: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b01) |->
      ($countones(mem_be) == 2 && mem_be[0] == mem_be[1] &&
       mem_wdata == {(NLANES/2){mem_wdata[15:0]}}));

  // R7: full strobe on word store
  a_r7_word_store: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b10) |-> (&mem_be));

  // R8: misaligned or invalid access never strobes memory
  a_r8_no_access_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad_align) |-> (!mem_we && !mem_re));

  // R9: stalled response frozen and requester held off
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  a_r9_no_take_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R10: strobes only on acceptance, address word aligned
  a_r10_strobe_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (req_valid && req_ready && mem_addr[1:0] == 2'b00 &&
                            !(mem_we && mem_re)));
endmodule

bind endian_lane_lsu endian_lane_lsu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .big_q     (big_q),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_err   (rsp_err)
);

// File: tb/sim_endian_lane_lsu.sv
`timescale 1ns/1ps
module sim_endian_lane_lsu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] mem_addr;
  logic        mem_we, mem_re;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_err;

  always #5 clk = ~clk;

  endian_lane_lsu u0 (.*);

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic        big;
    logic        wr;
    logic [1:0]  sz;
    logic [1:0]  a;
    logic [31:0] d;
    logic [3:0]  be;
    logic [31:0] w;
    logic [31:0] r;
    logic        err;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 2'b10, 2'd0, 32'h11223344, 4'b1111, 32'h11223344, 32'h0, 1'b0},
    '{1'b0, 1'b0, 2'b00, 2'd0, 32'h11223344, 4'b0000, 32'h0, 32'h00000044, 1'b0},
    '{1'b0, 1'b0, 2'b00, 2'd3, 32'h11223344, 4'b0000, 32'h0, 32'h00000011, 1'b0},
    '{1'b0, 1'b0, 2'b01, 2'd2, 32'h11223344, 4'b0000, 32'h0, 32'h00001122, 1'b0},
    '{1'b0, 1'b0, 2'b01, 2'd0, 32'h11223344, 4'b0000, 32'h0, 32'h00003344, 1'b0},
    '{1'b0, 1'b0, 2'b10, 2'd0, 32'h11223344, 4'b0000, 32'h0, 32'h11223344, 1'b0},
    '{1'b0, 1'b1, 2'b00, 2'd1, 32'h000000AB, 4'b0010, 32'hABABABAB, 32'h0, 1'b0},
    '{1'b0, 1'b1, 2'b01, 2'd2, 32'h0000BEEF, 4'b1100, 32'hBEEFBEEF, 32'h0, 1'b0},
    '{1'b0, 1'b0, 2'b01, 2'd1, 32'h11223344, 4'b0000, 32'h0, 32'h0, 1'b1},
    '{1'b0, 1'b1, 2'b10, 2'd2, 32'h11223344, 4'b0000, 32'h0, 32'h0, 1'b1},
    '{1'b1, 1'b1, 2'b10, 2'd0, 32'h11223344, 4'b1111, 32'h11223344, 32'h0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 2'd0, 32'h11223344, 4'b0000, 32'h0, 32'h00000011, 1'b0},
    '{1'b1, 1'b0, 2'b00, 2'd3, 32'h11223344, 4'b0000, 32'h0, 32'h00000044, 1'b0},
    '{1'b1, 1'b0, 2'b00, 2'd1, 32'h11223344, 4'b0000, 32'h0, 32'h00000022, 1'b0},
    '{1'b1, 1'b0, 2'b01, 2'd0, 32'h11223344, 4'b0000, 32'h0, 32'h00001122, 1'b0},
    '{1'b1, 1'b0, 2'b01, 2'd2, 32'h11223344, 4'b0000, 32'h0, 32'h00003344, 1'b0},
    '{1'b1, 1'b0, 2'b10, 2'd0, 32'h11223344, 4'b0000, 32'h0, 32'h11223344, 1'b0},
    '{1'b1, 1'b1, 2'b00, 2'd1, 32'h000000AB, 4'b0100, 32'hABABABAB, 32'h0, 1'b0},
    '{1'b1, 1'b1, 2'b01, 2'd0, 32'h0000BEEF, 4'b1100, 32'hBEEFBEEF, 32'h0, 1'b0},
    '{1'b1, 1'b1, 2'b01, 2'd2, 32'h0000BEEF, 4'b0011, 32'hBEEFBEEF, 32'h0, 1'b0},
    '{1'b1, 1'b0, 2'b11, 2'd0, 32'h11223344, 4'b0000, 32'h0, 32'h0, 1'b1}
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.err) return "R8";
    if (v.wr) return (v.sz == 2'b00) ? "R5" : (v.sz == 2'b01) ? "R6" : "R7";
    return (v.sz == 2'b00) ? "R2" : (v.sz == 2'b01) ? "R3" : "R4";
  endfunction

  task automatic do_reset(input logic big);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_big_endian = big;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive at a falling edge, check memory side before the rising edge,
  // check the response at the following falling edge.
  task automatic apply(input vec_t v);
    string t;
    t = tag_of(v);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = v.wr;
    req_size  = v.sz;
    req_addr  = 32'h0000_0100 | 32'(v.a);
    req_wdata = v.d;
    mem_rdata = v.d;
    #1;
    chk("R10", "mem_addr", mem_addr, 32'h0000_0100);
    chk(t, "mem_we", 32'(mem_we), 32'(v.wr && !v.err));
    chk(t, "mem_re", 32'(mem_re), 32'(!v.wr && !v.err));
    if (v.wr && !v.err) begin
      chk(t, "mem_be", 32'(mem_be), 32'(v.be));
      chk(t, "mem_wdata", mem_wdata, v.w);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(t, "rsp_data", rsp_data, v.r);
    chk(t, "rsp_err", 32'(rsp_err), 32'(v.err));
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic cur;
    vec_t v;
    do_reset(1'b0);
    cur = 1'b0;
    #1;
    chk("R9", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R9", "reset req_ready", 32'(req_ready), 32'd1);
    chk("R10", "idle mem_we", 32'(mem_we), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].big != cur) begin
        do_reset(TBL[i].big);
        cur = TBL[i].big;
      end
      apply(TBL[i]);
    end

    // R1: pin change after reset is ignored (still big-endian here)
    @(negedge clk);
    cfg_big_endian = 1'b0;
    v = '{1'b1, 1'b0, 2'b00, 2'd0, 32'h11223344, 4'b0000, 32'h0, 32'h00000011, 1'b0};
    repeat (2) @(negedge clk);
    apply(v);
    chk("R1", "latched big mode byte", rsp_data, 32'h00000011);

    // R1: reset with little-endian, then raise pin
    do_reset(1'b0);
    @(negedge clk);
    cfg_big_endian = 1'b1;
    v = '{1'b0, 1'b0, 2'b00, 2'd0, 32'h11223344, 4'b0000, 32'h0, 32'h00000044, 1'b0};
    apply(v);
    chk("R1", "latched little mode byte", rsp_data, 32'h00000044);

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_size  = 2'b00;
    req_addr  = 32'h0000_0102;
    mem_rdata = 32'hA1B2C3D4;
    @(negedge clk);
    req_write = 1'b1;
    req_size  = 2'b10;
    req_addr  = 32'h0000_0200;
    req_wdata = 32'hCAFEF00D;
    #1;
    chk("R9", "stall req_ready", 32'(req_ready), 32'd0);
    chk("R9", "stall mem_we", 32'(mem_we), 32'd0);
    chk("R9", "stall rsp_data", rsp_data, 32'h000000B2);
    repeat (3) @(negedge clk);
    chk("R9", "held rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R9", "held rsp_data", rsp_data, 32'h000000B2);
    rsp_ready = 1'b1;
    #1;
    chk("R9", "release req_ready", 32'(req_ready), 32'd1);
    chk("R7", "release mem_we", 32'(mem_we), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "store rsp_data", rsp_data, 32'h0);
    chk("R9", "store rsp_valid", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk("R9", "drained rsp_valid", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule